// File: doc/BRIEF.md
# Three-wire serial control-word loader

This block takes 24-bit control words that an external controller sends over three slow lines: a serial clock, a data line and a latch enable. It runs on a fast system clock. Each line passes through a two-flop synchronizer, and edges are detected in the system clock domain. On each rising edge of the serial clock, the block samples the data line and shifts it into a 24-bit register, most significant bit first.

A word is committed only on the rising edge of latch enable. At that edge the two lowest bits of the word are read as a destination code. The upper 22 bits are stored as payload in the chosen destination latch: the reference divider latch, the counter latch, the function latch, or an initialization latch. The initialization latch also writes the function latch.

Each latch update is announced by a one-cycle load strobe for that destination. Latch enable may rise after a number of serial clocks other than 24. In that case the word is dropped, a sticky framing-error flag is raised, and the bit count starts again. The serial lines are assumed to meet minimum timing: data is stable 10 ns around each clock edge, clock high and low times are at least 25 ns, latch enable follows the last clock by at least 10 ns, and the latch enable pulse is at least 20 ns wide. Each of these intervals must span at least two system clock periods.

Top module: `serial_word_loader`

## Requirements
- R1: After reset, all four latches hold zero, all load strobes are low and the framing-error flag is low.
- R2: Bits are taken on the serial clock rising edge, most significant first. After a committed 24-bit word, the selected latch holds word bits [23:2] as its 22-bit payload.
- R3: Destination code 2'b00 in word bits [1:0] updates only the reference latch (`ref_word_o`) and pulses only `ref_load_o`.
- R4: Code 2'b01 updates only the counter latch (`abc_word_o`) and pulses only `abc_load_o`.
- R5: Code 2'b10 updates only the function latch (`func_word_o`) and pulses only `func_load_o`.
- R6: Code 2'b11 writes the same payload into both the initialization latch and the function latch, and pulses `init_load_o` and `func_load_o` together.
- R7: A latch that is not selected keeps its value, and its strobe stays low.
- R8: Every load strobe is high for exactly one system clock per commit.
- R9: If latch enable rises after fewer or more than 24 serial clocks, no latch changes and no strobe pulses. `frame_err_o` then goes high and stays high until reset.
- R10: Every latch enable rising edge restarts the bit count, so a correct 24-bit word sent after a bad frame is committed normally.
- R11: A serial clock rising edge seen in the same synchronized cycle as the latch enable rising edge is shifted in first and counts toward the 24 bits.
- R12: Shifting bits without a latch enable rising edge changes no latch and pulses no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock line (asynchronous) |
| ser_data_i | input | 1 | Serial data line (asynchronous) |
| ser_le_i | input | 1 | Latch enable line (asynchronous) |
| ref_word_o | output | 22 | Reference divider latch payload |
| abc_word_o | output | 22 | Counter latch payload |
| func_word_o | output | 22 | Function latch payload |
| init_word_o | output | 22 | Initialization latch payload |
| ref_load_o | output | 1 | One-cycle strobe on reference latch update |
| abc_load_o | output | 1 | One-cycle strobe on counter latch update |
| func_load_o | output | 1 | One-cycle strobe on function latch update |
| init_load_o | output | 1 | One-cycle strobe on initialization latch update |
| frame_err_o | output | 1 | Sticky flag for a word with the wrong bit count |

## Verification
The final serial clock rising edge and the latch enable rising edge can be detected in the same system cycle. In that cycle the block must both shift a bit and judge the frame. The bench provokes this by raising both lines at the same instant after 23 ordinary bits. It then expects a clean commit of the full word, with no framing error, because the simultaneous bit must be counted before the length check. Code 2'b11 is the second overlap: two latches and two strobes update in one cycle. The bench checks that both latches and both strobe counts move together.

// File: rtl/swl_pkg.sv
// Package: shared sizes and destination codes for the serial word loader.
// Assumes a fixed two-bit destination code in the lowest bits of each word.
package swl_pkg;
    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 2;
    localparam int PAY_W    = WORD_W - ADDR_W;
    localparam int NUM_DEST = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        DST_REF  = 2'b00,
        DST_ABC  = 2'b01,
        DST_FUNC = 2'b10,
        DST_INIT = 2'b11
    } dest_e;
endpackage

// File: rtl/line_sync.sv
// Module: line_sync
// Brings W asynchronous lines into the clk domain through STAGES flops each.
// Assumes every input holds its level for at least STAGES clk periods.
module line_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw line levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Pass the levels down the chain one stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign level_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
// Module: edge_detect
// Flags a one-cycle rise for each synchronized line.
// Assumes the inputs are already in the clk domain.
module edge_detect #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] last_q;

    // Remember the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level_i;
    end

    assign rise_o = level_i & ~last_q;
endmodule

// File: rtl/word_assembler.sv
// Module: word_assembler
// Shifts serial bits in MSB first, counts them, and on a latch rise either
// issues a commit of the full word or flags a bad frame. A bit edge in the
// same cycle as the latch rise is shifted and counted before the check.
module word_assembler #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise_i,
    input  logic              bit_val_i,
    input  logic              latch_rise_i,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o,
    output logic              bad_o
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] sr_q, sr_nx;
    logic [CNT_W-1:0]  cnt_q, cnt_nx;

    // Next shift register and saturating bit count.
    always_comb begin
        sr_nx  = sr_q;
        cnt_nx = cnt_q;
        if (bit_rise_i) begin
            sr_nx = {sr_q[WORD_W-2:0], bit_val_i};
            if (cnt_q != CAP) cnt_nx = cnt_q + 1'b1;
        end
    end

    // Shift, count, and judge the frame on a latch rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= '0;
            cnt_q    <= '0;
            commit_o <= 1'b0;
            bad_o    <= 1'b0;
            word_o   <= '0;
        end else begin
            sr_q     <= sr_nx;
            cnt_q    <= latch_rise_i ? '0 : cnt_nx;
            commit_o <= latch_rise_i && (cnt_nx == FULL);
            bad_o    <= latch_rise_i && (cnt_nx != FULL);
            if (latch_rise_i && (cnt_nx == FULL)) word_o <= sr_nx;
        end
    end
endmodule

// File: rtl/latch_bank.sv
// Module: latch_bank
// Holds one payload latch per destination code and loads the addressed one
// on commit; the init code also loads the function latch. Strobes are
// registered with the latches so they align with the new value.
module latch_bank
    import swl_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int ADDR_W = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit_i,
    input  logic [WORD_W-1:0]                    word_i,
    output logic [(1<<ADDR_W)-1:0][WORD_W-ADDR_W-1:0] lat_o,
    output logic [(1<<ADDR_W)-1:0]               load_o
);
    localparam int ND = 1 << ADDR_W;
    localparam int PW = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] code;
    logic [PW-1:0]     payload;
    assign code    = word_i[ADDR_W-1:0];
    assign payload = word_i[WORD_W-1:ADDR_W];

    genvar d;
    generate
        for (d = 0; d < ND; d++) begin : g_dest
            logic hit;
            if (d == int'(DST_FUNC)) begin : g_func
                assign hit = (code == ADDR_W'(d)) || (code == ADDR_W'(DST_INIT));
            end else begin : g_plain
                assign hit = (code == ADDR_W'(d));
            end

            // Load this destination and pulse its strobe when addressed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lat_o[d]  <= '0;
                    load_o[d] <= 1'b0;
                end else begin
                    load_o[d] <= commit_i && hit;
                    if (commit_i && hit) lat_o[d] <= payload;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/serial_word_loader.sv
// Module: serial_word_loader (top)
// Three-wire serial receiver that routes 24-bit words into four latches by
// their two-bit code. Assumes serial line intervals exceed two clk periods.
module serial_word_loader
    import swl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_data_i,
    input  logic             ser_le_i,
    output logic [PAY_W-1:0] ref_word_o,
    output logic [PAY_W-1:0] abc_word_o,
    output logic [PAY_W-1:0] func_word_o,
    output logic [PAY_W-1:0] init_word_o,
    output logic             ref_load_o,
    output logic             abc_load_o,
    output logic             func_load_o,
    output logic             init_load_o,
    output logic             frame_err_o
);
    logic [2:0]          lvl;
    logic [1:0]          rise;
    logic                commit, bad;
    logic [WORD_W-1:0]   word;
    logic [NUM_DEST-1:0][PAY_W-1:0] lat;
    logic [NUM_DEST-1:0] load;
    logic                err_q;

    line_sync #(.W(3), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ser_le_i, ser_data_i, ser_clk_i}),
        .level_o(lvl)
    );

    edge_detect #(.W(2)) u_edge (
        .clk(clk), .rst_n(rst_n),
        .level_i({lvl[2], lvl[0]}),
        .rise_o(rise)
    );

    word_assembler #(.WORD_W(WORD_W)) u_asm (
        .clk(clk), .rst_n(rst_n),
        .bit_rise_i(rise[0]), .bit_val_i(lvl[1]), .latch_rise_i(rise[1]),
        .commit_o(commit), .word_o(word), .bad_o(bad)
    );

    latch_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .commit_i(commit), .word_i(word),
        .lat_o(lat), .load_o(load)
    );

    // Sticky framing error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   err_q <= 1'b0;
        else if (bad) err_q <= 1'b1;
    end

    assign ref_word_o  = lat[DST_REF];
    assign abc_word_o  = lat[DST_ABC];
    assign func_word_o = lat[DST_FUNC];
    assign init_word_o = lat[DST_INIT];
    assign ref_load_o  = load[DST_REF];
    assign abc_load_o  = load[DST_ABC];
    assign func_load_o = load[DST_FUNC];
    assign init_load_o = load[DST_INIT];
    assign frame_err_o = err_q;
endmodule

// File: rtl/swl_checker.sv
// Module: swl_checker
// Temporal properties on the loader's ports, bound to every instance.
module swl_checker
    import swl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PAY_W-1:0] ref_word_o,
    input logic [PAY_W-1:0] abc_word_o,
    input logic [PAY_W-1:0] func_word_o,
    input logic [PAY_W-1:0] init_word_o,
    input logic             ref_load_o,
    input logic             abc_load_o,
    input logic             func_load_o,
    input logic             init_load_o,
    input logic             frame_err_o
);
    p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_load_o, abc_load_o, func_load_o}));
    p_ref_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load_o |=> !ref_load_o);
    p_func_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        func_load_o |=> !func_load_o);
    p_ref_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_load_o |-> $stable(ref_word_o));
    p_abc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !abc_load_o |-> $stable(abc_word_o));
    p_func_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !func_load_o |-> $stable(func_word_o));
    p_init_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !init_load_o |-> $stable(init_word_o));
    p_init_pairs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_load_o |-> (func_load_o && func_word_o == init_word_o));
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o);
endmodule

bind serial_word_loader swl_checker u_swl_checker (
    .clk(clk), .rst_n(rst_n),
    .ref_word_o(ref_word_o), .abc_word_o(abc_word_o),
    .func_word_o(func_word_o), .init_word_o(init_word_o),
    .ref_load_o(ref_load_o), .abc_load_o(abc_load_o),
    .func_load_o(func_load_o), .init_load_o(init_load_o),
    .frame_err_o(frame_err_o)
);

// File: tb/tb_serial_word_loader.sv
module tb_serial_word_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [21:0] ref_w, abc_w, func_w, init_w;
    logic ref_l, abc_l, func_l, init_l, ferr;

    int checks = 0;
    int fails  = 0;
    int cnt_l [4];
    logic [21:0] exp_w [4];
    int exp_c [4];

    always #5 clk = ~clk;

    serial_word_loader dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_data_i(sdat), .ser_le_i(sle),
        .ref_word_o(ref_w), .abc_word_o(abc_w), .func_word_o(func_w), .init_word_o(init_w),
        .ref_load_o(ref_l), .abc_load_o(abc_l), .func_load_o(func_l), .init_load_o(init_l),
        .frame_err_o(ferr)
    );

    // Count strobe cycles at the falling edge (R8: one cycle per commit).
    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_l)  cnt_l[0]++;
            if (abc_l)  cnt_l[1]++;
            if (func_l) cnt_l[2]++;
            if (init_l) cnt_l[3]++;
        end
    end

    localparam logic [23:0] VEC [8] = '{
        24'hA5C3F0, 24'h123455, 24'hFEDCBA, 24'h0F0F0F,
        24'h800001, 24'h7FFFFE, 24'h3C3C3F, 24'hFFFFFC
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bits(input logic [23:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            sdat = w[i];
            wait_n(2);
            sclk = 1'b1;
            wait_n(4);
            sclk = 1'b0;
            wait_n(2);
        end
    endtask

    task automatic pulse_le();
        wait_n(2);
        sle = 1'b1;
        wait_n(4);
        sle = 1'b0;
        wait_n(6);
    endtask

    task automatic model_commit(input logic [23:0] w);
        int d;
        d = int'(w[1:0]);
        exp_w[d] = w[23:2];
        exp_c[d]++;
        if (d == 3) begin
            exp_w[2] = w[23:2];
            exp_c[2]++;
        end
    endtask

    task automatic check_all(input string req);
        check({req, " ref"},  {10'd0, ref_w},  {10'd0, exp_w[0]});
        check({req, " abc"},  {10'd0, abc_w},  {10'd0, exp_w[1]});
        check({req, " func"}, {10'd0, func_w}, {10'd0, exp_w[2]});
        check({req, " init"}, {10'd0, init_w}, {10'd0, exp_w[3]});
        for (int d = 0; d < 4; d++)
            check({req, " R8 strobe count"}, cnt_l[d], exp_c[d]);
    endtask

    initial begin
        wait_n(200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [23:0] w;
        for (int d = 0; d < 4; d++) begin
            exp_w[d] = '0; exp_c[d] = 0; cnt_l[d] = 0;
        end
        wait_n(4);
        // R1: reset state
        check("R1 ref",  {10'd0, ref_w},  32'd0);
        check("R1 func", {10'd0, func_w}, 32'd0);
        check("R1 strobes", {28'd0, ref_l, abc_l, func_l, init_l}, 32'd0);
        check("R1 err", {31'd0, ferr}, 32'd0);
        rst_n = 1'b1;
        wait_n(3);

        // R2..R7 table walk: codes 00/01/10/11 in bits [1:0]
        for (int v = 0; v < 8; v++) begin
            send_bits(VEC[v], 23, 0);
            pulse_le();
            model_commit(VEC[v]);
            check_all("R2-vec R3 R4 R5 R6 R7");
        end
        check("R9 no error on good frames", {31'd0, ferr}, 32'd0);

        // R12: bits shifted with no latch enable change nothing
        send_bits(24'h555554, 23, 0);
        wait_n(6);
        check_all("R12");
        pulse_le();   // 24 bits already in: commits
        model_commit(24'h555554);
        check_all("R12 then R3 commit");

        // R9: short frame (23 bits) dropped, error set
        send_bits(24'hABCDE1, 23, 1);
        pulse_le();
        check_all("R9 short");
        check("R9 err short", {31'd0, ferr}, 32'd1);

        // R10: good word after bad frame commits; R9 error stays
        send_bits(24'h13579A, 23, 0);
        pulse_le();
        model_commit(24'h13579A);
        check_all("R10");
        check("R9 sticky", {31'd0, ferr}, 32'd1);

        // R9: long frame (25 bits) dropped
        send_bits(24'hFFFFFF, 23, 0);
        send_bits(24'h000000, 0, 0);
        pulse_le();
        check_all("R9 long");

        // R11: last serial clock rise together with latch enable rise
        w = 24'h2468AD;
        send_bits(w, 23, 1);
        sdat = w[0];
        wait_n(2);
        sclk = 1'b1;
        sle  = 1'b1;
        wait_n(4);
        sclk = 1'b0;
        sle  = 1'b0;
        wait_n(6);
        model_commit(w);
        check_all("R11");

        // R1: reset clears latches and sticky error
        rst_n = 1'b0;
        wait_n(3);
        for (int d = 0; d < 4; d++) exp_w[d] = '0;
        check_all("R1 re-reset");
        check("R1 err cleared", {31'd0, ferr}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule